// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit channel of a classic programmable interval timer. It counts timer ticks, given as a clock enable, from the moment a count is loaded or a mode is written. From the number of ticks counted and the loaded count it drives one output pin. Six modes are supported: a terminal-count flag, a retriggerable one-shot, a rate pulse, a square wave, and software- and hardware-triggered strobes. A loaded value of zero stands for 65536. Codes 6 and 7 act as codes 2 and 3.

A gate input pauses counting in the periodic modes and restarts it in the two retriggerable modes. The host side can freeze the remaining count, or a status byte, into holding registers and read them back one byte per read strobe. The block also reports how many counted ticks remain until its output next changes, so that a surrounding model can schedule its next event. A parameter gives the channel index, and the index sets the reset value of the registered gate level: 1 for channels 0 and 1, 0 for channel 2.

Top module: `pit_channel`

## Requirements
- R1: While `rst` is high the channel takes mode 3 and an effective count of 65536. After reset `out_pin` is 1 and `nxt_ticks` is 32768, and a latched count reads as 0x00 then 0x00. The gate bit of the status byte latched on the first clock after reset is 1 when CHAN_IDX is 0 or 1, and 0 when CHAN_IDX is 2.
- R2: A count load or a mode write clears the elapsed-tick counter, and a mode write also clears the read byte pointer. In mode 0 the output is 0 until the elapsed ticks reach the count, then it stays 1.
- R3: In mode 1 the output is 1 while the elapsed ticks are below the count and 0 after that. A rising edge on `gate_in` restarts the counting from zero.
- R4: In mode 2 the output is 1 for exactly the counted tick states where the elapsed ticks are a nonzero multiple of the count. It repeats without a reload.
- R5: In mode 3 the output is 1 for the first (count+1)/2 ticks of each period of `count` ticks and 0 for the rest. An odd count therefore gives the extra tick to the high phase.
- R6: In modes 4 and 5 the output is 1 only while the elapsed ticks equal the count. In mode 5 a rising gate edge restarts counting from zero.
- R7: A loaded value of 0 acts as 65536. Mode codes 6 and 7 behave as modes 2 and 3.
- R8: In modes 2 and 3 a low `gate_in` holds the elapsed counter, so the output and the remaining count do not move. In modes 0 and 4 the gate level has no effect.
- R9: `latch_cnt` freezes the remaining count, which is count minus elapsed ticks, floored at 0 in the one-shot modes. Reads then return the low byte and then the high byte. A second latch before both bytes are read is ignored. Without a latch, reads return the live remaining count in the same byte order.
- R10: `latch_st` freezes a status byte. Bit 7 is the output, bit 6 is the registered gate level, bits 5:3 are 0 and bits 2:0 are the written mode code. A pending status byte is returned by the next read before any count byte.
- R11: When `nxt_vld` is 1, `nxt_ticks` is the number of counted ticks until `out_pin` changes. `nxt_vld` is 0 with `nxt_ticks` 0 when no change will follow: modes 0 and 1 once the count is reached, modes 4 and 5 one tick after it, and modes 2 and 3 with a count of 1 once no edge remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One timer tick when high |
| gate_in | input | 1 | Gate level |
| load_wr | input | 1 | Load strobe for `load_val` |
| load_val | input | CNT_W | Count to load; 0 means 65536 |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 3 | Mode code 0 to 7 |
| latch_cnt | input | 1 | Freeze the remaining count for reading |
| latch_st | input | 1 | Freeze the status byte for reading |
| rd_req | input | 1 | Read one byte |
| rd_data | output | 8 | Byte returned by the last read |
| out_pin | output | 1 | Channel output |
| nxt_vld | output | 1 | An output change is still ahead |
| nxt_ticks | output | CNT_W+1 | Counted ticks until that change |

## Verification
The bench builds the block twice from the same stimulus: once with CHAN_IDX 0 and once with CHAN_IDX 2. Comparing their first status bytes after reset shows that each channel index gets its own gate default. CNT_W stays at 16, which leaves the 65536-tick wrap of a zero load reachable in one run. That makes the full-range count boundary (R7) and the reset remaining count of 0x0000 directly observable. Small counts of 2 to 5 bring every mode's edges, odd-count square-wave split and strobe tick within a few cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_CNT_W = 16;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pit_mode_e;

    localparam logic [2:0] PIT_RESET_MODE = 3'd3;

    typedef struct packed {
        logic       cnt_lat;
        logic       st_lat;
        logic       rd_hi;
        logic [7:0] st_byte;
    } rb_state_t;

    // Codes 6 and 7 fold onto the periodic modes.
    function automatic pit_mode_e norm_mode(input logic [2:0] m);
        case (m)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return pit_mode_e'(m);
        endcase
    endfunction

    function automatic logic is_periodic(input pit_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic is_retrig(input pit_mode_e m);
        return (m == M_ONESHOT) || (m == M_HWSTROBE);
    endfunction

    function automatic logic [7:0] pack_status(input logic o, input logic g,
                                               input logic [2:0] m);
        return {o, g, 3'b000, m};
    endfunction

endpackage

// File: rtl/pit_elapsed.sv
module pit_elapsed
    import pit_pkg::*;
#(
    parameter int CNT_W    = PIT_CNT_W,
    parameter int CHAN_IDX = 0,
    localparam int ELAP_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              gate_in,
    input  logic              load_wr,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    output logic [2:0]        mode_raw,
    output pit_mode_e         mode_eff,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ELAP_W-1:0] eff_cnt,
    output logic [ELAP_W-1:0] elap,
    output logic              started,
    output logic              gate_q
);

    localparam logic GATE_RST = (CHAN_IDX != 2);
    localparam logic [ELAP_W-1:0] FULL_CNT = ELAP_W'(1) << CNT_W;

    logic gate_rise;
    logic restart;
    logic advance;
    logic [ELAP_W-1:0] elap_nxt;

    assign mode_eff  = norm_mode(mode_raw);
    assign eff_cnt   = (cnt_q == '0) ? FULL_CNT : {1'b0, cnt_q};
    assign gate_rise = gate_in && !gate_q;
    assign restart   = mode_wr || load_wr || (is_retrig(mode_eff) && gate_rise);
    assign advance   = tick_en && (!is_periodic(mode_eff) || gate_in);

    always_comb begin
        if (is_periodic(mode_eff)) begin
            elap_nxt = (elap == eff_cnt - ELAP_W'(1)) ? '0 : elap + ELAP_W'(1);
        end else if (elap <= eff_cnt) begin
            elap_nxt = elap + ELAP_W'(1);
        end else begin
            elap_nxt = elap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_raw <= PIT_RESET_MODE;
            cnt_q    <= '0;
            elap     <= '0;
            started  <= 1'b0;
            gate_q   <= GATE_RST;
        end else begin
            gate_q <= gate_in;
            if (mode_wr) begin
                mode_raw <= mode_val;
            end
            if (load_wr) begin
                cnt_q <= load_val;
            end
            if (restart) begin
                elap    <= '0;
                started <= 1'b0;
            end else if (advance) begin
                elap    <= elap_nxt;
                started <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pit_wave.sv
module pit_wave
    import pit_pkg::*;
#(
    parameter int CNT_W   = PIT_CNT_W,
    localparam int ELAP_W = CNT_W + 1
) (
    input  pit_mode_e         mode_eff,
    input  logic [ELAP_W-1:0] eff_cnt,
    input  logic [ELAP_W-1:0] elap,
    input  logic              started,
    output logic              out_w,
    output logic              nxt_vld,
    output logic [ELAP_W-1:0] nxt_ticks,
    output logic [ELAP_W-1:0] remaining
);

    logic [ELAP_W-1:0] half;
    logic [ELAP_W-1:0] to_cnt;
    logic              below;
    logic              unit_cnt;
    logic              vld_raw;
    logic [ELAP_W-1:0] nxt_raw;

    assign half     = (eff_cnt + ELAP_W'(1)) >> 1;
    assign to_cnt   = eff_cnt - elap;
    assign below    = elap < eff_cnt;
    assign unit_cnt = (eff_cnt == ELAP_W'(1));

    always_comb begin
        out_w   = 1'b0;
        vld_raw = 1'b0;
        nxt_raw = '0;
        case (mode_eff)
            M_TERM: begin
                out_w   = !below;
                vld_raw = below;
                nxt_raw = to_cnt;
            end
            M_ONESHOT: begin
                out_w   = below;
                vld_raw = below;
                nxt_raw = to_cnt;
            end
            M_RATE: begin
                out_w   = started && (elap == '0);
                vld_raw = !unit_cnt || !started;
                nxt_raw = out_w ? ELAP_W'(1) : to_cnt;
                if (unit_cnt) begin
                    nxt_raw = ELAP_W'(1);
                end
            end
            M_SQUARE: begin
                out_w   = elap < half;
                vld_raw = !unit_cnt;
                nxt_raw = out_w ? (half - elap) : to_cnt;
            end
            default: begin
                out_w   = (elap == eff_cnt);
                vld_raw = (elap <= eff_cnt);
                nxt_raw = below ? to_cnt : ELAP_W'(1);
            end
        endcase
    end

    assign nxt_vld   = vld_raw;
    assign nxt_ticks = vld_raw ? nxt_raw : '0;
    assign remaining = (is_periodic(mode_eff) || below) ? to_cnt : '0;

endmodule

// File: rtl/pit_readback.sv
module pit_readback
    import pit_pkg::*;
#(
    parameter int CNT_W   = PIT_CNT_W,
    localparam int ELAP_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_cnt,
    input  logic              latch_st,
    input  logic              rd_req,
    input  logic              seq_clr,
    input  logic [ELAP_W-1:0] remaining,
    input  logic [7:0]        status_live,
    output logic [7:0]        rd_data
);

    rb_state_t        st;
    logic [CNT_W-1:0] held;
    logic [CNT_W-1:0] live;
    logic [CNT_W-1:0] src;

    // A full-range remaining count wraps to zero in the 16-bit view.
    assign live = remaining[CNT_W] ? '0 : remaining[CNT_W-1:0];
    assign src  = st.cnt_lat ? held : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            held    <= '0;
            rd_data <= '0;
        end else begin
            if (latch_cnt && !st.cnt_lat) begin
                held       <= live;
                st.cnt_lat <= 1'b1;
            end
            if (latch_st && !st.st_lat) begin
                st.st_byte <= status_live;
                st.st_lat  <= 1'b1;
            end
            if (rd_req) begin
                if (st.st_lat) begin
                    rd_data   <= st.st_byte;
                    st.st_lat <= 1'b0;
                end else begin
                    rd_data  <= st.rd_hi ? src[15:8] : src[7:0];
                    st.rd_hi <= !st.rd_hi;
                    if (st.cnt_lat && st.rd_hi) begin
                        st.cnt_lat <= 1'b0;
                    end
                end
            end
            if (seq_clr) begin
                st.rd_hi <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W    = PIT_CNT_W,
    parameter int CHAN_IDX = 0,
    localparam int ELAP_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              gate_in,
    input  logic              load_wr,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    input  logic              latch_cnt,
    input  logic              latch_st,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              out_pin,
    output logic              nxt_vld,
    output logic [ELAP_W-1:0] nxt_ticks
);

    logic [2:0]        mode_raw;
    pit_mode_e         mode_eff;
    logic [CNT_W-1:0]  cnt_q;
    logic [ELAP_W-1:0] eff_cnt;
    logic [ELAP_W-1:0] elap;
    logic              started;
    logic              gate_q;
    logic [ELAP_W-1:0] remaining;
    logic [7:0]        status_live;

    pit_elapsed #(.CNT_W(CNT_W), .CHAN_IDX(CHAN_IDX)) elap_i (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .gate_in  (gate_in),
        .load_wr  (load_wr),
        .load_val (load_val),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .mode_raw (mode_raw),
        .mode_eff (mode_eff),
        .cnt_q    (cnt_q),
        .eff_cnt  (eff_cnt),
        .elap     (elap),
        .started  (started),
        .gate_q   (gate_q)
    );

    pit_wave #(.CNT_W(CNT_W)) wave_i (
        .mode_eff  (mode_eff),
        .eff_cnt   (eff_cnt),
        .elap      (elap),
        .started   (started),
        .out_w     (out_pin),
        .nxt_vld   (nxt_vld),
        .nxt_ticks (nxt_ticks),
        .remaining (remaining)
    );

    assign status_live = pack_status(out_pin, gate_q, mode_raw);

    pit_readback #(.CNT_W(CNT_W)) rb_i (
        .clk         (clk),
        .rst         (rst),
        .latch_cnt   (latch_cnt),
        .latch_st    (latch_st),
        .rd_req      (rd_req),
        .seq_clr     (mode_wr),
        .remaining   (remaining),
        .status_live (status_live),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = PIT_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             gate_in,
    input logic             gate_q,
    input logic             load_wr,
    input logic             mode_wr,
    input logic             out_pin,
    input logic             nxt_vld,
    input logic [CNT_W:0]   nxt_ticks,
    input pit_mode_e        mode_eff,
    input logic [CNT_W-1:0] cnt_q
);

    logic quiet;
    assign quiet = !load_wr && !mode_wr;

    AST_RESET_OUT_HIGH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> out_pin); // R1

    AST_TERM_LOW_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load_wr && !mode_wr && mode_eff == M_TERM) |=> !out_pin); // R2

    AST_RATE_PULSE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == M_RATE && out_pin && tick_en && gate_in && cnt_q != CNT_W'(1) && quiet)
        |=> !out_pin); // R4

    AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        ((mode_eff == M_SWSTROBE || mode_eff == M_HWSTROBE) && out_pin && tick_en && quiet)
        |=> !out_pin); // R6

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((mode_eff == M_RATE || mode_eff == M_SQUARE) && !gate_in && quiet)
        |=> $stable(out_pin)); // R8

    AST_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (nxt_vld && nxt_ticks == (CNT_W+1)'(1) && tick_en && gate_in && !gate_q ? 1'b0 :
         (nxt_vld && nxt_ticks == (CNT_W+1)'(1) && tick_en && gate_in && quiet))
        |=> (out_pin != $past(out_pin))); // R11

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .gate_in   (gate_in),
    .gate_q    (gate_q),
    .load_wr   (load_wr),
    .mode_wr   (mode_wr),
    .out_pin   (out_pin),
    .nxt_vld   (nxt_vld),
    .nxt_ticks (nxt_ticks),
    .mode_eff  (mode_eff),
    .cnt_q     (cnt_q)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

    localparam int CNT_W = 16;
    localparam int NV    = 25;
    // {mode[2:0], count[15:0], ticks[7:0], out, nxt_vld, nxt_ticks[16:0]}
    localparam logic [45:0] VEC [NV] = '{
        {3'd0, 16'd5, 8'd4, 1'b0, 1'b1, 17'd1},   // R2
        {3'd0, 16'd5, 8'd5, 1'b1, 1'b0, 17'd0},   // R2
        {3'd0, 16'd5, 8'd9, 1'b1, 1'b0, 17'd0},   // R2
        {3'd1, 16'd3, 8'd0, 1'b1, 1'b1, 17'd3},   // R3
        {3'd1, 16'd3, 8'd2, 1'b1, 1'b1, 17'd1},   // R3
        {3'd1, 16'd3, 8'd3, 1'b0, 1'b0, 17'd0},   // R3
        {3'd2, 16'd4, 8'd0, 1'b0, 1'b1, 17'd4},   // R4
        {3'd2, 16'd4, 8'd3, 1'b0, 1'b1, 17'd1},   // R4
        {3'd2, 16'd4, 8'd4, 1'b1, 1'b1, 17'd1},   // R4
        {3'd2, 16'd4, 8'd5, 1'b0, 1'b1, 17'd3},   // R4
        {3'd2, 16'd4, 8'd8, 1'b1, 1'b1, 17'd1},   // R4
        {3'd3, 16'd5, 8'd0, 1'b1, 1'b1, 17'd3},   // R5
        {3'd3, 16'd5, 8'd2, 1'b1, 1'b1, 17'd1},   // R5
        {3'd3, 16'd5, 8'd3, 1'b0, 1'b1, 17'd2},   // R5
        {3'd3, 16'd5, 8'd4, 1'b0, 1'b1, 17'd1},   // R5
        {3'd3, 16'd5, 8'd5, 1'b1, 1'b1, 17'd3},   // R5
        {3'd3, 16'd4, 8'd1, 1'b1, 1'b1, 17'd1},   // R5
        {3'd3, 16'd4, 8'd2, 1'b0, 1'b1, 17'd2},   // R5
        {3'd4, 16'd3, 8'd2, 1'b0, 1'b1, 17'd1},   // R6
        {3'd4, 16'd3, 8'd3, 1'b1, 1'b1, 17'd1},   // R6
        {3'd4, 16'd3, 8'd4, 1'b0, 1'b0, 17'd0},   // R6
        {3'd5, 16'd2, 8'd2, 1'b1, 1'b1, 17'd1},   // R6
        {3'd5, 16'd2, 8'd3, 1'b0, 1'b0, 17'd0},   // R6
        {3'd6, 16'd4, 8'd4, 1'b1, 1'b1, 17'd1},   // R7
        {3'd7, 16'd5, 8'd3, 1'b0, 1'b1, 17'd2}    // R7
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_en = 1'b0;
    logic             gate_in = 1'b1;
    logic             load_wr = 1'b0;
    logic [CNT_W-1:0] load_val = '0;
    logic             mode_wr = 1'b0;
    logic [2:0]       mode_val = '0;
    logic             latch_cnt = 1'b0;
    logic             latch_st = 1'b0;
    logic             rd_req = 1'b0;
    logic [7:0]       rd_data, rd_data_c2;
    logic             out_pin, out_pin_c2;
    logic             nxt_vld, nxt_vld_c2;
    logic [CNT_W:0]   nxt_ticks, nxt_ticks_c2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pit_channel #(.CNT_W(CNT_W), .CHAN_IDX(0)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
        .load_wr(load_wr), .load_val(load_val), .mode_wr(mode_wr), .mode_val(mode_val),
        .latch_cnt(latch_cnt), .latch_st(latch_st), .rd_req(rd_req),
        .rd_data(rd_data), .out_pin(out_pin), .nxt_vld(nxt_vld), .nxt_ticks(nxt_ticks)
    );

    pit_channel #(.CNT_W(CNT_W), .CHAN_IDX(2)) dut_c2_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
        .load_wr(load_wr), .load_val(load_val), .mode_wr(mode_wr), .mode_val(mode_val),
        .latch_cnt(latch_cnt), .latch_st(latch_st), .rd_req(rd_req),
        .rd_data(rd_data_c2), .out_pin(out_pin_c2), .nxt_vld(nxt_vld_c2),
        .nxt_ticks(nxt_ticks_c2)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic setup(input logic [2:0] m, input logic [15:0] c);
        mode_wr  = 1'b1;
        mode_val = m;
        load_wr  = 1'b1;
        load_val = c;
        @(negedge clk);
        mode_wr = 1'b0;
        load_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b0, output logic [7:0] b2);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        b0 = rd_data;
        b2 = rd_data_c2;
    endtask

    task automatic pulse_latch(input bit cnt, input bit st);
        latch_cnt = cnt;
        latch_st  = st;
        @(negedge clk);
        latch_cnt = 1'b0;
        latch_st  = 1'b0;
    endtask

    task automatic gate_bounce();
        gate_in = 1'b0;
        @(negedge clk);
        gate_in = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b;
        logic [45:0] v;

        // Reset defaults, with the status latched on the first clock out of reset
        repeat (3) @(negedge clk);
        rst      = 1'b0;
        latch_st = 1'b1;
        @(negedge clk);
        latch_st = 1'b0;
        chk("R1 out after reset", int'(out_pin), 1);
        chk("R1 nxt_ticks after reset", int'(nxt_ticks), 32768);
        rd(a, b);
        chk("R1 status ch0 gate default", int'(a), 'hC3);
        chk("R1 status ch2 gate default", int'(b), 'h83);
        pulse_latch(1'b1, 1'b0);
        rd(a, b);
        chk("R1 latched low byte of 65536", int'(a), 0);
        rd(a, b);
        chk("R1 latched high byte of 65536", int'(a), 0);

        // Table walk: mode, count, ticks -> out, nxt_vld, nxt_ticks
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            gate_in = 1'b1;
            setup(v[45:43], v[42:27]);
            ticks(int'(v[26:19]));
            chk($sformatf("R2-R7 vec %0d out", k), int'(out_pin), int'(v[18]));
            chk($sformatf("R11 vec %0d nxt_vld", k), int'(nxt_vld), int'(v[17]));
            chk($sformatf("R11 vec %0d nxt_ticks", k), int'(nxt_ticks), int'(v[16:0]));
        end

        // R7: zero load is 65536 ticks
        setup(3'd0, 16'd0);
        ticks(65535);
        chk("R7 zero load out before 65536", int'(out_pin), 0);
        chk("R7 zero load nxt_ticks", int'(nxt_ticks), 1);
        ticks(1);
        chk("R7 zero load out at 65536", int'(out_pin), 1);

        // R8: gate low holds mode 3, ignored in mode 0
        setup(3'd3, 16'd4);
        gate_in = 1'b0;
        ticks(5);
        chk("R8 mode3 gate low out held", int'(out_pin), 1);
        pulse_latch(1'b1, 1'b0);
        rd(a, b);
        chk("R8 mode3 gate low remaining low byte", int'(a), 4);
        rd(a, b);
        chk("R8 mode3 gate low remaining high byte", int'(a), 0);
        gate_in = 1'b1;
        ticks(2);
        chk("R8 mode3 counts after gate high", int'(out_pin), 0);
        setup(3'd0, 16'd3);
        gate_in = 1'b0;
        ticks(3);
        chk("R8 mode0 gate ignored", int'(out_pin), 1);
        gate_in = 1'b1;
        @(negedge clk);

        // R3: mode 1 retrigger
        setup(3'd1, 16'd3);
        ticks(3);
        chk("R3 mode1 expired", int'(out_pin), 0);
        gate_bounce();
        chk("R3 mode1 retriggered high", int'(out_pin), 1);
        ticks(3);
        chk("R3 mode1 expired again", int'(out_pin), 0);

        // R6: mode 5 retrigger
        setup(3'd5, 16'd2);
        ticks(3);
        chk("R6 mode5 past strobe", int'(out_pin), 0);
        gate_bounce();
        ticks(2);
        chk("R6 mode5 strobe after retrigger", int'(out_pin), 1);

        // R9: latch, ignored second latch, byte order, live read
        setup(3'd0, 16'h1234);
        ticks(16);
        pulse_latch(1'b1, 1'b0);
        ticks(5);
        pulse_latch(1'b1, 1'b0);
        rd(a, b);
        chk("R9 latched low byte", int'(a), 'h24);
        rd(a, b);
        chk("R9 latched high byte", int'(a), 'h12);
        rd(a, b);
        chk("R9 live low byte", int'(a), 'h1F);
        rd(a, b);
        chk("R9 live high byte", int'(a), 'h12);

        // R10: status first, then count
        setup(3'd4, 16'd7);
        ticks(7);
        pulse_latch(1'b1, 1'b1);
        rd(a, b);
        chk("R10 status byte first", int'(a), 'hC4);
        rd(a, b);
        chk("R10 count low after status", int'(a), 0);
        rd(a, b);
        chk("R10 count high after status", int'(a), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule